// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management frames towards an Ethernet PHY. Software, or a local sequencer, writes one packed command word. The word names the PHY, the register, the write data and whether the operation is a read or a write. The block then produces the serial management clock (MDC) and the data line (MDIO) with a separate output enable, so that the line can be released while the PHY answers. Only one transaction is in flight at any time. A command that arrives while a frame is running is dropped.

The block reports its result through one status word. Bit 28 of that word marks completion, and bits 15:0 carry the value returned by the most recent read. The MDC rate is set by the parameter `MDC_HALF`, which is the number of system clocks in each half period of MDC. The preamble length is the parameter `PRE_BITS`, which defaults to 35.

A state machine sequences each frame. The states are IDLE, PREAMBLE, START, OPCODE, PHY_ADDR, REG_ADDR, TURN and DATA. The transitions are:
- IDLE→PREAMBLE when a command is accepted.
- PREAMBLE→START after `PRE_BITS` bits.
- START→OPCODE after 2 bits.
- OPCODE→PHY_ADDR after 2 bits.
- PHY_ADDR→REG_ADDR after 5 bits.
- REG_ADDR→TURN after 5 bits.
- TURN→DATA after 2 bits for a write, or after 1 bit for a read.
- DATA→IDLE after 16 bits, which also raises the completion flag.

Every bit lasts one MDC period, and a bit ends on the falling edge of MDC.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word is zero, MDC is low, the output enable is low and the MDIO output is high.
- R2: `cmd_word` field positions are: bit 27 requests a read, bit 26 requests a write, bits 25:21 are the PHY address, bits 20:16 are the register number and bits 15:0 are the write data. A command with both bits 27 and 26 set runs as a read. A command with neither bit set is ignored.
- R3: Every frame opens with `PRE_BITS` (default 35) consecutive 1 bits, driven with the output enable high.
- R4: After the preamble, the master drives the start pattern 0,1, then the operation code (0,1 for a write, 1,0 for a read), then the PHY address and then the register number, each most significant bit first.
- R5: In a write, the master drives the turnaround bits 1,0 and then the 16 write data bits, most significant bit first.
- R6: In a read, the output enable is low for one turnaround bit and the 16 data bits. MDIO is sampled at the rising edges of MDC, most significant bit first. A PHY that never drives the line (pulled high) yields 0xFFFF.
- R7: MDC is low while idle, and each bit lasts 2·`MDC_HALF` clocks. A write frame therefore takes 67 bits and a read frame 66 bits from acceptance to completion. The MDIO output changes only while MDC is low.
- R8: Status bit 28 rises on the clock edge that ends the last data bit. It clears on the edge that accepts the next command. Status bits 15:0 hold the last read result, and all other status bits are zero.
- R9: A command presented while a frame runs is ignored. This includes a command on the very edge that ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle strobe that presents `cmd_word` |
| cmd_word | input | 28 | Packed command: read, write, PHY, register, data |
| status_word | output | 32 | Bit 28 completion flag, bits 15:0 read result |
| mdc | output | 1 | Management clock towards the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (high: master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Two things can happen on the same clock edge: the completion of a frame and the arrival of a new command. The bench counts clocks from the accepting edge and presents a second command exactly on the edge where the last data bit ends. It then expects three things: completion set, the second command dropped, and no further MDC activity. A separate scoreboard decodes every frame on MDC rising edges and compares it with what the driver queued. A behavioural PHY answers reads, leaves one address unanswered so that the pulled-high line is read, and records writes so that a later read returns the written value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int CMD_W  = 28;
    localparam int STAT_W = 32;

    localparam int RD_BIT   = 27;
    localparam int WR_BIT   = 26;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;
    localparam int DONE_BIT = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TURN,
        ST_DATA
    } mdio_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int HC_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [HC_W-1:0] TERM = HC_W'(MDC_HALF - 1);

    logic [HC_W-1:0] cnt_q;
    logic            term;

    assign term = run && (cnt_q == TERM);
    assign rise = term && !mdc;
    assign fall = term && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  rg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MAXLEN = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W  = $clog2(MAXLEN) + 1;
    localparam int SR_W   = 2 + 2 + PHY_W + REG_W + 2 + DATA_W;

    mdio_state_t        state_q, state_d;
    logic [CNT_W-1:0]   bitcnt_q;
    logic [SR_W-1:0]    tx_sr_q;
    logic [DATA_W-1:0]  rx_sr_q;
    logic               rd_q;
    logic               go, advance;

    assign go      = start && (state_q == ST_IDLE);
    assign advance = fall && (bitcnt_q == '0);

    function automatic logic [CNT_W-1:0] seg_len(input mdio_state_t s, input logic rd);
        case (s)
            ST_START, ST_OP: seg_len = CNT_W'(1);
            ST_PHY:          seg_len = CNT_W'(PHY_W - 1);
            ST_REG:          seg_len = CNT_W'(REG_W - 1);
            ST_TURN:         seg_len = rd ? CNT_W'(0) : CNT_W'(1);
            ST_DATA:         seg_len = CNT_W'(DATA_W - 1);
            default:         seg_len = '0;
        endcase
    endfunction

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)      state_d = ST_PRE;
            ST_PRE:   if (advance) state_d = ST_START;
            ST_START: if (advance) state_d = ST_OP;
            ST_OP:    if (advance) state_d = ST_PHY;
            ST_PHY:   if (advance) state_d = ST_REG;
            ST_REG:   if (advance) state_d = ST_TURN;
            ST_TURN:  if (advance) state_d = ST_DATA;
            ST_DATA:  if (advance) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            tx_sr_q  <= '0;
            rx_sr_q  <= '0;
            rd_q     <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (go) begin
                tx_sr_q  <= {2'b01, (start_rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wdata};
                rd_q     <= start_rd;
                done     <= 1'b0;
                bitcnt_q <= CNT_W'(PRE_BITS - 1);
            end else if (fall) begin
                bitcnt_q <= advance ? seg_len(state_d, rd_q) : bitcnt_q - 1'b1;
                if (state_q != ST_PRE) tx_sr_q <= tx_sr_q << 1;
                if (state_q == ST_DATA && advance) begin
                    done <= 1'b1;
                    if (rd_q) rd_data <= rx_sr_q;
                end
            end
            if (rise && rd_q && state_q == ST_DATA)
                rx_sr_q <= {rx_sr_q[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_START, ST_OP, ST_PHY, ST_REG: begin
                mdio_o  = tx_sr_q[SR_W-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = rd_q ? 1'b1 : tx_sr_q[SR_W-1];
                mdio_oe = !rd_q;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    // checker state: preamble bit count
    logic [CNT_W-1:0] pre_falls;
    always_ff @(posedge clk) begin
        if (!rst_n || go)                    pre_falls <= '0;
        else if (fall && state_q == ST_PRE)  pre_falls <= pre_falls + 1'b1;
    end

    assert_preamble_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_PRE) |-> (pre_falls == CNT_W'(PRE_BITS)));

    assert_done_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));

    assert_no_restart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_BITS = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [STAT_W-1:0] status_word,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, rise, fall, done, start;
    logic [DATA_W-1:0] rd_data;

    assign start = cmd_wr && (cmd_word[RD_BIT] || cmd_word[WR_BIT]);

    mdio_clk_div #(.MDC_HALF(MDC_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_fsm #(.PRE_BITS(PRE_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_rd (cmd_word[RD_BIT]),
        .phy      (cmd_word[PHY_LSB +: PHY_W]),
        .rg       (cmd_word[REG_LSB +: REG_W]),
        .wdata    (cmd_word[DATA_W-1:0]),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data)
    );

    always_comb begin
        status_word           = '0;
        status_word[DONE_BIT] = done;
        status_word[DATA_W-1:0] = rd_data;
    end

    assert_mdio_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);

    assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int H = 4;
    localparam int WR_BITS = 67;
    localparam int RD_BITS = 66;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [27:0] cmd_word = '0;
    logic [31:0] status_word;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_master #(.MDC_HALF(H), .PRE_BITS(35)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .status_word(status_word), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] d;
    } exp_t;

    exp_t        exp_q[$];
    int          n_checks = 0;
    int          n_err = 0;
    int          frames_seen = 0;
    bit          finished = 0;
    logic [15:0] phy_regs [0:1023];
    logic        b_o  [0:66];
    logic        b_oe [0:66];
    int          nb = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [4:0] field5(input int lo);
        logic [4:0] v = '0;
        for (int i = 0; i < 5; i++) v = {v[3:0], b_o[lo+i]};
        return v;
    endfunction

    function automatic bit frame_is_rd();
        return (nb >= 39) && b_o[37] && !b_o[38];
    endfunction

    task automatic decode_frame();
        int   bad;
        exp_t e;
        logic [15:0] d;
        frames_seen++;
        bad = 0;
        for (int i = 0; i < 35; i++) if (!(b_o[i] && b_oe[i])) bad++;
        chk("R3 preamble non-one bits", bad, 0);
        chk("R4 start pattern", {b_o[35], b_o[36]}, 2'b01);
        bad = 0;
        for (int i = 35; i < 49; i++) if (!b_oe[i]) bad++;
        chk("R4 header driven", bad, 0);
        if (exp_q.size() == 0) begin
            chk("R9 unexpected frame", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        chk("R4 opcode", {b_o[37], b_o[38]}, e.rd ? 2'b10 : 2'b01);
        chk("R4 phy address", field5(39), e.phy);
        chk("R4 register", field5(44), e.rg);
        if (!e.rd) begin
            chk("R5 turnaround", {b_o[49], b_o[50], b_oe[49], b_oe[50]}, 4'b1011);
            d = '0;
            bad = 0;
            for (int i = 51; i < 67; i++) begin
                d = {d[14:0], b_o[i]};
                if (!b_oe[i]) bad++;
            end
            chk("R5 write data", d, e.d);
            chk("R5 data driven", bad, 0);
            phy_regs[{e.phy, e.rg}] = d;
        end else begin
            bad = 0;
            for (int i = 49; i < 66; i++) if (b_oe[i]) bad++;
            chk("R6 line released", bad, 0);
        end
    endtask

    // monitor: records a bit on each MDC rise
    always @(posedge mdc) begin
        b_o[nb]  = mdio_o;
        b_oe[nb] = mdio_oe;
        nb++;
        if ((nb == RD_BITS && frame_is_rd()) || nb == WR_BITS) begin
            decode_frame();
            nb = 0;
        end
    end

    // PHY model: drives read data after MDC falls
    always @(negedge mdc) begin
        logic [4:0] p, r;
        if (frame_is_rd() && nb >= 50 && nb <= 65) begin
            p = field5(39);
            r = field5(44);
            mdio_i = (p == 5'd31) ? 1'b1 : phy_regs[{p, r}][15 - (nb - 50)];
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic present(input logic rd, input logic wr, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] d);
        @(negedge clk);
        cmd_word = {rd, wr, p, r, d};
        cmd_wr   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    // driver: queues the expected frame, runs it and checks status
    task automatic run_cmd(input logic rd, input logic wr, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] d);
        exp_t e;
        int   k;
        int   len;
        e.rd  = rd;
        e.phy = p;
        e.rg  = r;
        e.d   = rd ? ((p == 5'd31) ? 16'hFFFF : phy_regs[{p, r}]) : d;
        exp_q.push_back(e);
        len = rd ? RD_BITS : WR_BITS;
        present(rd, wr, p, r, d);
        chk("R8 done cleared on accept", status_word[28], 0);
        k = 0;
        while (!status_word[28] && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk("R7 frame duration", k, 2 * H * len);
        chk("R8 reserved status bits", {status_word[31:29], status_word[27:16]}, 0);
        chk("R8 scoreboard drained", exp_q.size(), 0);
        if (rd) chk("R6 read result", status_word[15:0], e.d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int f0;
        logic [15:0] held;
        for (int i = 0; i < 1024; i++) phy_regs[i] = 16'(i * 16'h0101 + 16'h0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status_word, 0);
        chk("R1 idle pins", {mdc, mdio_oe, mdio_o}, 3'b001);

        run_cmd(1'b0, 1'b1, 5'd1, 5'd4, 16'h01E0);
        run_cmd(1'b1, 1'b0, 5'd1, 5'd4, 16'h0000);
        chk("R6 read-back of written value", status_word[15:0], 16'h01E0);
        run_cmd(1'b1, 1'b0, 5'd31, 5'd3, 16'h0000);
        chk("R6 absent PHY", status_word[15:0], 16'hFFFF);
        run_cmd(1'b1, 1'b0, 5'd0, 5'd0, 16'h0000);
        run_cmd(1'b0, 1'b1, 5'd21, 5'd10, 16'hA5C3);
        run_cmd(1'b1, 1'b1, 5'd21, 5'd10, 16'h1111);
        chk("R2 both bits act as read", status_word[15:0], 16'hA5C3);

        // R2: neither bit set
        f0 = frames_seen;
        present(1'b0, 1'b0, 5'd2, 5'd2, 16'h7777);
        repeat (200) @(negedge clk);
        chk("R2 empty command keeps done", status_word[28], 1);
        chk("R2 empty command starts no frame", frames_seen - f0, 0);

        // R9: command while busy
        f0 = frames_seen;
        held = status_word[15:0];
        exp_q.push_back(exp_t'{1'b0, 5'd3, 5'd9, 16'h0F0F});
        present(1'b0, 1'b1, 5'd3, 5'd9, 16'h0F0F);
        repeat (20) @(negedge clk);
        present(1'b1, 1'b0, 5'd4, 5'd1, 16'h0000);
        while (!status_word[28]) @(negedge clk);
        repeat (300) @(negedge clk);
        chk("R9 busy command dropped", frames_seen - f0, 1);
        chk("R9 read data untouched", status_word[15:0], held);
        chk("R9 done still set", status_word[28], 1);

        // R9: command on the completion edge
        f0 = frames_seen;
        exp_q.push_back(exp_t'{1'b0, 5'd5, 5'd6, 16'hC33C});
        present(1'b0, 1'b1, 5'd5, 5'd6, 16'hC33C);
        repeat (2 * H * WR_BITS - 1) @(posedge clk);
        @(negedge clk);
        cmd_word = {1'b1, 1'b0, 5'd6, 5'd7, 16'h0000};
        cmd_wr   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_wr   = 1'b0;
        chk("R9 done set on collision edge", status_word[28], 1);
        chk("R7 MDC low at completion", mdc, 0);
        repeat (300) @(negedge clk);
        chk("R9 collision command dropped", frames_seen - f0, 1);
        chk("R7 idle pins after frames", {mdc, mdio_oe}, 2'b00);
        chk("R9 scoreboard empty", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule